// File: doc/BRIEF.md
# Pattern Memory Word Formatter

This block takes a serial stream of modulation bits, each accompanied by framing flags, and turns every accepted bit into one byte for a pattern memory. Each byte holds the data bit, the RF-on burst flag, an event-marker flag and a restart flag. It also carries fixed filler bits that the playback logic expects. The stored image is therefore eight times the size of the payload, and a memory of N bytes holds at most N payload bits.

The bytes are written to consecutive addresses through a simple write port, one cycle after each bit is accepted. The byte made for the bit flagged as last carries the restart flag. At that point the address wraps back to zero and a done pulse appears alongside the write.

The input is a valid/ready stream. A bit is taken on a rising clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must hold its bit and flags steady, and nothing is consumed. `in_ready` is low in three cases:
- during a synchronous clear;
- once every address up to the memory depth has been filled;
- after an overflow, until reset.

A valid bit offered to a full memory is refused and raises a sticky overflow flag. The clear input abandons a partly written pattern and restarts addressing at zero. It models the memory being overwritten when the operating mode changes.

Top module: `pattern_byte_writer`

## Requirements
- R1: Each accepted bit produces exactly one write, with `wr_en` high in the cycle after the accepting edge. Addresses start at 0 and rise by one per accepted bit, and no write appears without an accepted bit.
- R2: Byte bit 0 equals the data bit when the burst flag is 1, and is 0 when the burst flag is 0.
- R3: Byte bit 2 equals the burst flag supplied with the bit, where 1 means RF on.
- R4: The filler bits are fixed in every written byte: bit 1 = 0, bit 3 = 0, bit 4 = 1, bit 5 = 0.
- R5: Byte bit 6 equals the event-marker flag supplied with the bit.
- R6: Byte bit 7 is 1 only in the byte for a bit flagged last. `done` is high exactly in the cycle of that write.
- R7: After the last-flagged bit's byte, the next accepted bit is written to address 0.
- R8: Once MEM_DEPTH bytes have been written without a last flag, `in_ready` is low. A valid bit offered then sets `overflow`, and `overflow` stays set and `in_ready` stays low until `rst_n` is asserted. No write occurs.
- R9: While `clr` is high, `in_ready` is low and no bit is consumed. After a clear, the next accepted bit is written to address 0.
- R10: After reset, `wr_en`, `done` and `overflow` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear: abort download, address back to 0 |
| in_valid | input | 1 | Stream bit offered |
| in_ready | output | 1 | Block can take a bit this cycle |
| in_bit | input | 1 | Modulation data bit |
| in_burst | input | 1 | RF-on flag for this bit |
| in_mark | input | 1 | Event-marker flag for this bit |
| in_last | input | 1 | Bit closes the pattern |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory byte address |
| wr_data | output | 8 | Memory byte |
| done | output | 1 | Pulses with the write of the closing byte |
| overflow | output | 1 | Sticky: a bit was offered to a full memory |

## Verification
The bound checker checks the following on every cycle:
- Every handshake is followed by a write, and no write appears without one.
- The burst and marker flags are copied into the byte, and the filler bits hold their fixed values.
- The data bit is zeroed when the burst flag is off, and `done` coincides with the restart-flagged write.
- Consecutive bits wrap to address 0 after a last-flagged bit.
- `overflow` is sticky and blocks `in_ready`, and a clear blocks `in_ready`.

Some behaviours depend on a sequence of events, so only the bench's scenarios can show them:
- Address progression across idle gaps.
- The restart to address 0 after a clear that interrupts a pattern.
- Refusal of the bit that follows exactly MEM_DEPTH writes.
- Overflow surviving a clear and being removed only by reset.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int BYTE_W = 8;
  localparam int POS_DATA  = 0;
  localparam int POS_BURST = 2;
  localparam int POS_MARK  = 6;
  localparam int POS_RSTRT = 7;
  localparam logic [BYTE_W-1:0] FILLER = 8'b0001_0000;

  typedef struct packed {
    logic dbit;
    logic burst;
    logic mark;
    logic last;
  } bit_flags_t;
endpackage

// File: rtl/pmf_byte_pack.sv
module pmf_byte_pack
  import pmf_pkg::*;
(
  input  bit_flags_t        flags,
  output logic [BYTE_W-1:0] pbyte
);
  always_comb begin
    pbyte            = FILLER;
    pbyte[POS_DATA]  = flags.burst & flags.dbit;
    pbyte[POS_BURST] = flags.burst;
    pbyte[POS_MARK]  = flags.mark;
    pbyte[POS_RSTRT] = flags.last;
  end
endmodule

// File: rtl/pmf_addr_seq.sv
module pmf_addr_seq #(
  parameter int MEM_DEPTH = 1024,
  localparam int CNT_W = $clog2(MEM_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             advance,
  input  logic             last,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (advance)
      cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pmf_cap_guard.sv
module pmf_cap_guard #(
  parameter int MEM_DEPTH = 1024,
  localparam int CNT_W = $clog2(MEM_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] cnt,
  output logic             ready,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MEM_DEPTH);

  logic full;
  assign full  = (cnt == LIMIT);
  assign ready = !ovf && !full && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovf <= 1'b0;
    else if (in_valid && full)
      ovf <= 1'b1;
  end
endmodule

// File: rtl/pattern_byte_writer.sv
module pattern_byte_writer #(
  parameter int MEM_DEPTH = 1024,
  localparam int ADDR_W = $clog2(MEM_DEPTH),
  localparam int CNT_W  = $clog2(MEM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_burst,
  input  logic              in_mark,
  input  logic              in_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              overflow
);
  import pmf_pkg::*;

  logic             accept;
  logic [CNT_W-1:0] cnt;
  bit_flags_t       flags;
  logic [BYTE_W-1:0] pbyte;

  assign accept = in_valid && in_ready;
  assign flags  = '{dbit: in_bit, burst: in_burst, mark: in_mark, last: in_last};

  pmf_byte_pack u_pack (
    .flags (flags),
    .pbyte (pbyte)
  );

  pmf_addr_seq #(.MEM_DEPTH(MEM_DEPTH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .advance (accept),
    .last    (in_last),
    .cnt     (cnt)
  );

  pmf_cap_guard #(.MEM_DEPTH(MEM_DEPTH)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .cnt      (cnt),
    .ready    (in_ready),
    .ovf      (overflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      done    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= accept;
      done  <= accept && in_last;
      if (accept) begin
        wr_addr <= cnt[ADDR_W-1:0];
        wr_data <= pbyte;
      end
    end
  end
endmodule

// File: rtl/pmf_checker.sv
module pmf_checker #(
  parameter int MEM_DEPTH = 1024,
  localparam int ADDR_W = $clog2(MEM_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_burst,
  input logic              in_mark,
  input logic              in_last,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              done,
  input logic              overflow
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_accept_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> wr_en);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !wr_en);
  assert_idle_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2]) |-> !wr_data[0]);
  assert_burst_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (wr_data[2] == $past(in_burst)));
  assert_filler_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[5:3] == 3'b010 && !wr_data[1]));
  assert_mark_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (wr_data[6] == $past(in_mark)));
  assert_done_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done == (wr_en && wr_data[7]));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $past(acc) && $past(in_last)) |=> (wr_addr == '0));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_ovf_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !in_ready);
  assert_clr_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);
endmodule

bind pattern_byte_writer pmf_checker #(.MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_burst (in_burst),
  .in_mark  (in_mark),
  .in_last  (in_last),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .done     (done),
  .overflow (overflow)
);

// File: tb/pattern_byte_writer_test.sv
module pattern_byte_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, clr, in_valid, in_bit, in_burst, in_mark, in_last;
  logic in_ready, wr_en, done, overflow;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  logic [AW+8:0] sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_byte_writer #(.MEM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_burst(in_burst), .in_mark(in_mark), .in_last(in_last),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .overflow(overflow));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: offers one bit, waits for the handshake, pushes the expected write.
  task automatic send(input logic b, input logic bu, input logic mk, input logic ls);
    logic [7:0] eb;
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_burst = bu; in_mark = mk; in_last = ls;
    while (!in_ready) @(negedge clk);
    eb = {ls, mk, 1'b0, 1'b1, 1'b0, bu, 1'b0, bu & b};
    sb.push_back({ls, AW'(exp_addr), eb});
    exp_addr = ls ? 0 : exp_addr + 1;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares every write seen at the port.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1 unexpected write", int'(wr_addr), -1);
        end else begin
          logic [AW+8:0] e;
          e = sb.pop_front();
          chk(wr_addr == e[AW+7:8], "R1/R7 address", int'(wr_addr), int'(e[AW+7:8]));
          chk(wr_data[0] == e[0], "R2 data bit", int'(wr_data), int'(e[7:0]));
          chk(wr_data[2] == e[2], "R3 burst bit", int'(wr_data), int'(e[7:0]));
          chk(wr_data[5:3] == 3'b010 && !wr_data[1], "R4 filler", int'(wr_data), int'(e[7:0]));
          chk(wr_data[6] == e[6], "R5 marker bit", int'(wr_data), int'(e[7:0]));
          chk(wr_data[7] == e[7], "R6 restart bit", int'(wr_data), int'(e[7:0]));
          chk(done == e[AW+8], "R6 done", int'(done), int'(e[AW+8]));
        end
      end else begin
        chk(!done, "R6 done without write", int'(done), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_addr = 0;
    chk(!wr_en && !done, "R10 reset outputs", int'({wr_en, done}), 0);
    chk(!overflow, "R10 overflow clear", int'(overflow), 0);
    chk(in_ready, "R10 ready", int'(in_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0;
    in_bit = 1'b0; in_burst = 1'b0; in_mark = 1'b0; in_last = 1'b0;
    do_reset();

    // R1 R3 R5 R6: bursted pattern with varied data and markers
    send(1, 1, 0, 0); send(0, 1, 1, 0); send(1, 1, 1, 0); send(0, 1, 0, 0); send(1, 1, 0, 1);
    // R2 R7: burst off zeroes data bit, address restarts at 0
    send(1, 0, 0, 0); send(1, 0, 1, 0); send(1, 0, 0, 1);
    idle(2);
    // R1: address continues across a gap
    send(1, 1, 0, 0); idle(3); send(0, 1, 1, 0); send(1, 1, 0, 0);

    // R9: clear with valid held high consumes nothing
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; in_burst = 1'b1; clr = 1'b1;
    #1 chk(!in_ready, "R9 ready low during clear", int'(in_ready), 0);
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    exp_addr = 0;
    send(1, 1, 1, 0); send(0, 1, 0, 1);
    idle(2);

    // R8: fill every address, then offer one more bit
    for (int i = 0; i < DEPTH; i++) send(i[0], 1, i[1], 0);
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b0;
    #1 chk(!in_ready, "R8 ready low when full", int'(in_ready), 0);
    @(negedge clk);
    chk(overflow, "R8 overflow raised", int'(overflow), 1);
    in_valid = 1'b0;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    chk(overflow, "R8 overflow survives clear", int'(overflow), 1);
    chk(!in_ready, "R8 ready stays low", int'(in_ready), 0);

    do_reset();
    send(1, 1, 0, 1);
    idle(3);
    chk(sb.size() == 0, "R1 all writes seen", sb.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule